// File: doc/BRIEF.md
# Life-Cycle Transition Sequencer

This block runs one life-cycle state transition attempt each time software writes the start bit through the already claimed register interface. The target state, a 128-bit token and two control bits (external clock request and volatile raw unlock) arrive as register values. Nonvolatile storage is outside the block. At reset it loads the stored state and the stored attempt count from its boot inputs. It reports the state and count that should be written back on its `prog_state` and `xition_cnt` outputs.

A regular attempt always uses up one attempt, whether it succeeds or fails. It then moves the live state to a post-transition lock until the next reset. Success or failure shows in one-hot completion flags. Token hashing is not modelled: each target class is checked against a fixed 128-bit expected value. When the build parameter allows it, a volatile raw unlock moves the live state from RAW to TEST_UNLOCKED0 directly. It uses no attempt and does not lock, so the block accepts a further command without a reset.

Top module: `lc_xition_seq`

State encoding (4 bits): RAW=0, TEST_UNLOCKED0=1, TEST_LOCKED0=2, TEST_UNLOCKED1=3, DEV=4, PROD=5, RMA=6, SCRAP=7, POST_TRANSITION=8.

Legal moves and token classes:
- RAW to TEST_UNLOCKED0 needs the unlock token.
- TEST_UNLOCKED0 or TEST_UNLOCKED1 to TEST_LOCKED0 is unconditional.
- TEST_LOCKED0 to TEST_UNLOCKED1 needs the unlock token.
- Any TEST state to DEV or PROD needs the exit token.
- TEST_UNLOCKED*, DEV or PROD to RMA needs the RMA token.
- Any state except SCRAP and POST_TRANSITION to SCRAP is unconditional.

## Requirements
- R1: After reset, `ready` is 1, all four completion flags are 0, `cur_state` and `prog_state` equal `boot_state`, and `xition_cnt` equals `boot_cnt`.
- R2: A regular start with a legal target and the matching token sets `done_ok`, sets `prog_state` to the target, moves `cur_state` to POST_TRANSITION (8) and drops `ready`, all visible one cycle after the start.
- R3: At most one of `done_ok`, `err_xition`, `err_token` and `err_count` is 1 at any time.
- R4: Every regular attempt below the count limit increments `xition_cnt` by one and moves `cur_state` to POST_TRANSITION, even when it fails. A failed attempt leaves `prog_state` unchanged.
- R5: In POST_TRANSITION, start commands are ignored until reset: flags, count and `prog_state` do not change.
- R6: A target that is not a legal successor of the current state sets `err_xition`. A legal target whose token is wrong sets `err_token`. An unconditional target needs an all-zero token.
- R7: A start with `xition_cnt` equal to CNT_MAX sets `err_count` and changes neither the state nor the count, and `ready` stays 1.
- R8: `vol_unlock_rb` reads back 1 after a control write with `ctl_vol_unlock`=1 only when VOL_EN=1; otherwise it reads 0, and starts follow the regular path.
- R9: With the volatile bit set, a start from RAW to TEST_UNLOCKED0 with the unlock token sets `done_ok` and `cur_state`=1. The count, `prog_state` and `ready` stay unchanged, and a later regular start is accepted. Any other volatile start sets an error flag and also leaves the count and state unchanged.
- R10: `ext_clk_sel` is 1 two cycles after a control write with `ctl_ext_clk`=1 only when `cur_state` is RAW, a TEST state or RMA. In DEV, PROD, SCRAP or POST_TRANSITION it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_state | input | 4 | Stored state loaded at reset |
| boot_cnt | input | CW | Stored attempt count loaded at reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_ext_clk | input | 1 | External clock request bit |
| ctl_vol_unlock | input | 1 | Volatile raw unlock request bit |
| start | input | 1 | Start command pulse |
| target | input | 4 | Requested target state |
| token | input | 128 | Token (already hashed) |
| ready | output | 1 | Block accepts a start |
| done_ok | output | 1 | Last attempt succeeded |
| err_xition | output | 1 | Illegal target |
| err_token | output | 1 | Token mismatch |
| err_count | output | 1 | Attempt count exhausted |
| cur_state | output | 4 | Live state |
| xition_cnt | output | CW | Attempts used, to be stored |
| prog_state | output | 4 | State to be stored |
| ext_clk_sel | output | 1 | Effective external clock selection |
| vol_unlock_rb | output | 1 | Volatile unlock bit readback |

## Verification
If the live state register goes wrong, it shows within one cycle of the next start, as a wrong completion flag or a wrong successor. In POST_TRANSITION it shows at once as `ready` low. A count that slips shows on `xition_cnt` in the same cycle the attempt completes, and only in the limit case does it show as `err_count` in place of `done_ok`. A wrong gating of the clock request shows two cycles after the control write on `ext_clk_sel`.

// File: rtl/lc_seq_pkg.sv
package lc_seq_pkg;
  typedef enum logic [3:0] {
    ST_RAW   = 4'd0,
    ST_TU0   = 4'd1,
    ST_TL0   = 4'd2,
    ST_TU1   = 4'd3,
    ST_DEV   = 4'd4,
    ST_PROD  = 4'd5,
    ST_RMA   = 4'd6,
    ST_SCRAP = 4'd7,
    ST_POST  = 4'd8
  } lc_st_e;

  typedef enum logic [1:0] {
    TK_NONE   = 2'd0,
    TK_UNLOCK = 2'd1,
    TK_EXIT   = 2'd2,
    TK_RMA    = 2'd3
  } tok_cls_e;

  localparam int unsigned TOKW = 128;
endpackage

// File: rtl/lc_succ_chk.sv
module lc_succ_chk
  import lc_seq_pkg::*;
(
  input  logic [3:0] cur,
  input  logic [3:0] tgt,
  output logic       legal,
  output tok_cls_e   cls
);
  logic is_test;
  always_comb begin
    is_test = (cur == ST_TU0) || (cur == ST_TL0) || (cur == ST_TU1);
    legal   = 1'b0;
    cls     = TK_NONE;
    case (tgt)
      ST_TU0: begin
        legal = (cur == ST_RAW);
        cls   = TK_UNLOCK;
      end
      ST_TL0: legal = (cur == ST_TU0) || (cur == ST_TU1);
      ST_TU1: begin
        legal = (cur == ST_TL0);
        cls   = TK_UNLOCK;
      end
      ST_DEV, ST_PROD: begin
        legal = is_test;
        cls   = TK_EXIT;
      end
      ST_RMA: begin
        legal = (cur == ST_TU0) || (cur == ST_TU1) || (cur == ST_DEV) || (cur == ST_PROD);
        cls   = TK_RMA;
      end
      ST_SCRAP: legal = (cur != ST_SCRAP) && (cur != ST_POST);
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/lc_token_chk.sv
module lc_token_chk
  import lc_seq_pkg::*;
#(
  parameter logic [TOKW-1:0] UNLOCK_TOK = 128'h0,
  parameter logic [TOKW-1:0] EXIT_TOK   = 128'h0,
  parameter logic [TOKW-1:0] RMA_TOK    = 128'h0
) (
  input  tok_cls_e         cls,
  input  logic [TOKW-1:0]  token,
  output logic             match
);
  logic [TOKW-1:0] expect_tok;
  always_comb begin
    case (cls)
      TK_UNLOCK: expect_tok = UNLOCK_TOK;
      TK_EXIT:   expect_tok = EXIT_TOK;
      TK_RMA:    expect_tok = RMA_TOK;
      default:   expect_tok = '0;
    endcase
    match = (token == expect_tok);
  end
endmodule

// File: rtl/lc_xition_seq.sv
module lc_xition_seq
  import lc_seq_pkg::*;
#(
  parameter int unsigned     CW         = 5,
  parameter int unsigned     CNT_MAX    = 24,
  parameter bit              VOL_EN     = 1'b1,
  parameter logic [127:0]    UNLOCK_TOK = 128'h3c5a_0f1e_d2c3_b4a5_9687_7869_5a4b_3c2d,
  parameter logic [127:0]    EXIT_TOK   = 128'h8e7d_6c5b_4a39_2817_0f1e_2d3c_4b5a_6978,
  parameter logic [127:0]    RMA_TOK    = 128'h1122_3344_5566_7788_99aa_bbcc_ddee_ff01
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    boot_state,
  input  logic [CW-1:0] boot_cnt,
  input  logic          ctl_we,
  input  logic          ctl_ext_clk,
  input  logic          ctl_vol_unlock,
  input  logic          start,
  input  logic [3:0]    target,
  input  logic [127:0]  token,
  output logic          ready,
  output logic          done_ok,
  output logic          err_xition,
  output logic          err_token,
  output logic          err_count,
  output logic [3:0]    cur_state,
  output logic [CW-1:0] xition_cnt,
  output logic [3:0]    prog_state,
  output logic          ext_clk_sel,
  output logic          vol_unlock_rb
);
  localparam logic [CW-1:0] CNT_LIM = CW'(CNT_MAX);

  logic     legal, tok_ok, ext_q, vol_q, ext_ok, go;
  tok_cls_e cls;

  lc_succ_chk u_succ (
    .cur   (cur_state),
    .tgt   (target),
    .legal (legal),
    .cls   (cls)
  );

  lc_token_chk #(
    .UNLOCK_TOK (UNLOCK_TOK),
    .EXIT_TOK   (EXIT_TOK),
    .RMA_TOK    (RMA_TOK)
  ) u_tok (
    .cls   (cls),
    .token (token),
    .match (tok_ok)
  );

  assign go = start && ready;
  assign ext_ok = (cur_state == ST_RAW) || (cur_state == ST_TU0) || (cur_state == ST_TL0) ||
                  (cur_state == ST_TU1) || (cur_state == ST_RMA);

  // control bits; volatile bit only holds a 1 when the feature is built in
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q       <= 1'b0;
      vol_q       <= 1'b0;
      ext_clk_sel <= 1'b0;
    end else begin
      if (ctl_we) begin
        ext_q <= ctl_ext_clk;
        vol_q <= VOL_EN ? ctl_vol_unlock : 1'b0;
      end
      ext_clk_sel <= ext_q && ext_ok;
    end
  end
  assign vol_unlock_rb = vol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_state  <= boot_state;
      prog_state <= boot_state;
      xition_cnt <= boot_cnt;
      ready      <= 1'b1;
      done_ok    <= 1'b0;
      err_xition <= 1'b0;
      err_token  <= 1'b0;
      err_count  <= 1'b0;
    end else if (go) begin
      done_ok    <= 1'b0;
      err_xition <= 1'b0;
      err_token  <= 1'b0;
      err_count  <= 1'b0;
      if (VOL_EN && vol_q) begin
        // volatile path: no count, no lock, nothing to store
        if (cur_state != ST_RAW || target != ST_TU0) begin
          err_xition <= 1'b1;
        end else if (!tok_ok) begin
          err_token <= 1'b1;
        end else begin
          done_ok   <= 1'b1;
          cur_state <= ST_TU0;
        end
      end else if (xition_cnt >= CNT_LIM) begin
        err_count <= 1'b1;
      end else begin
        xition_cnt <= xition_cnt + 1'b1;
        cur_state  <= ST_POST;
        ready      <= 1'b0;
        if (!legal) begin
          err_xition <= 1'b1;
        end else if (!tok_ok) begin
          err_token <= 1'b1;
        end else begin
          done_ok    <= 1'b1;
          prog_state <= target;
        end
      end
    end
  end
endmodule

// File: rtl/lc_xition_seq_chk.sv
module lc_xition_seq_chk #(
  parameter int unsigned CW      = 5,
  parameter int unsigned CNT_MAX = 24,
  parameter bit          VOL_EN  = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          ready,
  input logic          done_ok,
  input logic          err_xition,
  input logic          err_token,
  input logic          err_count,
  input logic [3:0]    cur_state,
  input logic [CW-1:0] xition_cnt,
  input logic          ext_clk_sel,
  input logic          vol_unlock_rb
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_flags_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    armed |-> $onehot0({done_ok, err_xition, err_token, err_count}));

  assert_post_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (armed && cur_state == 4'd8) |=> (cur_state == 4'd8 && !ready));

  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (rst)
    armed |=> (xition_cnt == $past(xition_cnt) || xition_cnt == $past(xition_cnt) + 1'b1));

  assert_cnt_limit_R7: assert property (@(posedge clk) disable iff (rst)
    (armed && err_count) |-> (xition_cnt == CW'(CNT_MAX) && ready));

  assert_vol_gate_R8: assert property (@(posedge clk) disable iff (rst)
    vol_unlock_rb |-> VOL_EN);

  assert_ext_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (armed && ext_clk_sel) |-> (cur_state <= 4'd3 || cur_state == 4'd6 || $past(cur_state) != cur_state));
endmodule

bind lc_xition_seq lc_xition_seq_chk #(.CW(CW), .CNT_MAX(CNT_MAX), .VOL_EN(VOL_EN)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ready         (ready),
  .done_ok       (done_ok),
  .err_xition    (err_xition),
  .err_token     (err_token),
  .err_count     (err_count),
  .cur_state     (cur_state),
  .xition_cnt    (xition_cnt),
  .ext_clk_sel   (ext_clk_sel),
  .vol_unlock_rb (vol_unlock_rb)
);

// File: tb/lc_xition_seq_tb.sv
module lc_xition_seq_tb;
  localparam int CW = 5;
  localparam int CNT_MAX = 24;
  localparam logic [127:0] UNL = 128'h3c5a_0f1e_d2c3_b4a5_9687_7869_5a4b_3c2d;
  localparam logic [3:0] RAW = 0, TU0 = 1, TL0 = 2, TU1 = 3, DEV = 4, RMA = 6, SCRAP = 7, POST = 8;

  logic clk = 0, rst = 1;
  logic [3:0] boot_state = 0;
  logic [CW-1:0] boot_cnt = 0;
  logic ctl_we = 0, ctl_ext_clk = 0, ctl_vol_unlock = 0, start = 0;
  logic [3:0] target = 0;
  logic [127:0] token = 0;
  logic ready, done_ok, err_xition, err_token, err_count, ext_clk_sel, vol_unlock_rb;
  logic [3:0] cur_state, prog_state;
  logic [CW-1:0] xition_cnt;
  logic n_ready, n_done, n_ex, n_et, n_ec, n_ext, n_vol;
  logic [3:0] n_cur, n_prog;
  logic [CW-1:0] n_cnt;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  lc_xition_seq #(.CW(CW), .CNT_MAX(CNT_MAX)) u_dut (
    .clk(clk), .rst(rst), .boot_state(boot_state), .boot_cnt(boot_cnt),
    .ctl_we(ctl_we), .ctl_ext_clk(ctl_ext_clk), .ctl_vol_unlock(ctl_vol_unlock),
    .start(start), .target(target), .token(token),
    .ready(ready), .done_ok(done_ok), .err_xition(err_xition), .err_token(err_token),
    .err_count(err_count), .cur_state(cur_state), .xition_cnt(xition_cnt),
    .prog_state(prog_state), .ext_clk_sel(ext_clk_sel), .vol_unlock_rb(vol_unlock_rb));

  lc_xition_seq #(.CW(CW), .CNT_MAX(CNT_MAX), .VOL_EN(1'b0)) u_dut_nv (
    .clk(clk), .rst(rst), .boot_state(boot_state), .boot_cnt(boot_cnt),
    .ctl_we(ctl_we), .ctl_ext_clk(ctl_ext_clk), .ctl_vol_unlock(ctl_vol_unlock),
    .start(start), .target(target), .token(token),
    .ready(n_ready), .done_ok(n_done), .err_xition(n_ex), .err_token(n_et),
    .err_count(n_ec), .cur_state(n_cur), .xition_cnt(n_cnt),
    .prog_state(n_prog), .ext_clk_sel(n_ext), .vol_unlock_rb(n_vol));

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic [3:0] exp);
    chk(req, "flags{ok,ex,tok,cnt}", {done_ok, err_xition, err_token, err_count}, exp);
  endtask

  task automatic do_reset(input logic [3:0] st, input logic [CW-1:0] c);
    @(negedge clk);
    boot_state = st; boot_cnt = c; rst = 1; start = 0; ctl_we = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic wr_ctl(input logic ext, input logic vol);
    ctl_ext_clk = ext; ctl_vol_unlock = vol; ctl_we = 1;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic kick(input logic [3:0] tgt, input logic [127:0] tok);
    target = tgt; token = tok; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic t_reset;
    do_reset(TL0, 5'd7);
    chk("R1", "ready", ready, 1);
    chk_flags("R1", 4'b0000);
    chk("R1", "cur_state", cur_state, TL0);
    chk("R1", "prog_state", prog_state, TL0);
    chk("R1", "cnt", xition_cnt, 7);
  endtask

  task automatic t_regular_ok;
    do_reset(RAW, 5'd0);
    kick(TU0, UNL);
    chk_flags("R2", 4'b1000);
    chk("R2", "cur_state", cur_state, POST);
    chk("R2", "prog_state", prog_state, TU0);
    chk("R2", "ready", ready, 0);
    chk("R4", "cnt", xition_cnt, 1);
    kick(SCRAP, 128'h0);                      // R5: ignored in post state
    chk_flags("R5", 4'b1000);
    chk("R5", "cnt", xition_cnt, 1);
    chk("R5", "prog_state", prog_state, TU0);
    chk("R5", "cur_state", cur_state, POST);
  endtask

  task automatic t_failures;
    do_reset(RAW, 5'd3);
    kick(TU0, UNL ^ 128'h1);
    chk_flags("R6", 4'b0010);
    chk("R4", "cnt after bad token", xition_cnt, 4);
    chk("R4", "cur_state after bad token", cur_state, POST);
    chk("R4", "prog_state after bad token", prog_state, RAW);
    do_reset(RAW, 5'd0);
    kick(DEV, 128'h0);
    chk_flags("R6", 4'b0100);
    chk("R4", "cnt after illegal", xition_cnt, 1);
    do_reset(TU0, 5'd2);
    kick(TL0, 128'h10);
    chk_flags("R6", 4'b0010);
    chk("R4", "cnt uncond nonzero", xition_cnt, 3);
    do_reset(TU0, 5'd3);
    kick(TL0, 128'h0);
    chk_flags("R6", 4'b1000);
    chk("R6", "prog_state uncond", prog_state, TL0);
  endtask

  task automatic t_cnt_max;
    do_reset(TL0, 5'(CNT_MAX));
    kick(TU1, UNL);
    chk_flags("R7", 4'b0001);
    chk("R7", "cur_state", cur_state, TL0);
    chk("R7", "cnt", xition_cnt, CNT_MAX);
    chk("R7", "ready", ready, 1);
  endtask

  task automatic t_volatile;
    do_reset(RAW, 5'd5);
    wr_ctl(0, 1);
    chk("R8", "vol readback enabled", vol_unlock_rb, 1);
    chk("R8", "vol readback disabled build", n_vol, 0);
    kick(TU0, UNL);
    chk_flags("R9", 4'b1000);
    chk("R9", "cur_state", cur_state, TU0);
    chk("R9", "cnt", xition_cnt, 5);
    chk("R9", "prog_state", prog_state, RAW);
    chk("R9", "ready", ready, 1);
    chk("R8", "disabled build regular cur", n_cur, POST);
    chk("R8", "disabled build regular cnt", n_cnt, 6);
    wr_ctl(0, 0);
    kick(TL0, 128'h0);
    chk_flags("R9", 4'b1000);
    chk("R9", "cur after follow-up", cur_state, POST);
    chk("R9", "cnt after follow-up", xition_cnt, 6);
    chk("R9", "prog after follow-up", prog_state, TL0);
    do_reset(RAW, 5'd2);
    wr_ctl(0, 1);
    kick(TL0, 128'h0);
    chk_flags("R9", 4'b0100);
    chk("R9", "cnt after bad volatile", xition_cnt, 2);
    chk("R9", "cur after bad volatile", cur_state, RAW);
  endtask

  task automatic t_ext;
    do_reset(RAW, 5'd0);
    wr_ctl(1, 0);
    @(negedge clk);
    chk("R10", "ext in RAW", ext_clk_sel, 1);
    do_reset(DEV, 5'd0);
    wr_ctl(1, 0);
    @(negedge clk);
    chk("R10", "ext in DEV", ext_clk_sel, 0);
    do_reset(RMA, 5'd0);
    wr_ctl(1, 0);
    @(negedge clk);
    chk("R10", "ext in RMA", ext_clk_sel, 1);
  endtask

  initial begin
    t_reset();
    t_regular_ok();
    t_failures();
    t_cnt_max();
    t_volatile();
    t_ext();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule